// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block decides which control-memory word a microprogrammed control unit reads next. It holds the control address, which also serves as the read address of the control store. It also holds a single return-address register for one level of microcode subroutine. On every rising clock edge it loads the control address with one of four values: an incremented address, the branch target carried in the current microinstruction, the saved return address, or an address mapped from the instruction opcode.

The caller supplies three fields of the microinstruction that is executing. A 2-bit condition selector picks the status bit that gates a branch. A 2-bit branch kind picks the way the next address is formed. A 7-bit branch target completes the set. Alongside these it supplies the indirect flag and the 4-bit opcode taken from the data register, plus the accumulator word. The sign bit and the zero state of the accumulator both come from that word. The next address is a purely combinational function of these inputs and the two registers. A synchronous reset points the control address at the start of the fetch routine.

Top module: `useq_next_addr`

## Requirements
- R1: The condition selector chooses the gating bit: 0 gives a constant 1, 1 gives the indirect flag, 2 gives accumulator bit 15, and 3 gives 1 exactly when the accumulator word is zero.
- R2: With branch kind 0 (jump) and the selected condition at 1, the control address becomes the branch target after the next rising edge.
- R3: With branch kind 0 or 1 and the selected condition at 0, the control address becomes its old value plus one. Address 127 wraps to 0.
- R4: With branch kind 1 (call) and the selected condition at 1, the control address becomes the branch target and the return register becomes the old control address plus one, modulo 128. No other case changes the return register, and that includes a call whose condition is 0.
- R5: With branch kind 2 (return), the control address becomes the return register's value whatever the condition selector and status inputs hold.
- R6: With branch kind 3 (map), the control address becomes {0, opcode[3:0], 00}, so opcode k lands on address 4k, whatever the condition.
- R7: While reset is high at a rising edge, the control address is loaded with 64 and the return register is cleared to 0. A return taken just after reset therefore goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| condSel | input | 2 | Condition selector field of the current microinstruction |
| branchKind | input | 2 | Branch kind field: 0 jump, 1 call, 2 return, 3 map |
| branchTarget | input | 7 | Branch target address field |
| indirectBit | input | 1 | Indirect flag of the data register (its bit 15) |
| opcodeBits | input | 4 | Opcode bits of the data register (its bits 14..11) |
| acWord | input | 16 | Accumulator word, used for the sign and zero tests |
| ctlAddr | output | 7 | Control address, drives the control-memory read address |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that each check taken after a return or a call refers only to the return register as it stood in the cycle before. Reset is therefore never released for a single cycle in the middle of a property. The bench changes inputs only on falling edges and holds reset for whole cycles. It sweeps every pairing of condition selector and branch kind over status patterns that drive each condition both true and false. It also includes the all-zero accumulator, so every antecedent fires with settled, known values.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    BK_JUMP   = 2'b00,
    BK_CALL   = 2'b01,
    BK_RETURN = 2'b10,
    BK_MAP    = 2'b11
  } branchKind_e;

  typedef enum logic [1:0] {
    CS_ALWAYS   = 2'b00,
    CS_INDIRECT = 2'b01,
    CS_SIGN     = 2'b10,
    CS_ZERO     = 2'b11
  } condSel_e;

  // Strobes from the branch control to the address datapath.
  // All zero means "step to the next sequential address".
  typedef struct packed {
    logic takeTarget;
    logic saveReturn;
    logic takeReturn;
    logic takeMap;
  } seqStrobes_t;

endpackage

// File: rtl/useq_branch_ctl.sv
module useq_branch_ctl
  import useq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        condSel,
  input  logic [1:0]        branchKind,
  input  logic              indirectBit,
  input  logic [DATA_W-1:0] acWord,
  output seqStrobes_t       strobes
);

  logic acIsZero;
  logic acSign;
  logic condMet;

  assign acIsZero = (acWord == '0);
  assign acSign   = acWord[DATA_W-1];

  // Status-bit multiplexer.
  always_comb begin
    case (condSel)
      CS_ALWAYS:   condMet = 1'b1;
      CS_INDIRECT: condMet = indirectBit;
      CS_SIGN:     condMet = acSign;
      default:     condMet = acIsZero;
    endcase
  end

  // Branch kind decode into datapath strobes.
  always_comb begin
    strobes = '0;
    case (branchKind)
      BK_JUMP: begin
        strobes.takeTarget = condMet;
      end
      BK_CALL: begin
        strobes.takeTarget = condMet;
        strobes.saveReturn = condMet;
      end
      BK_RETURN: begin
        strobes.takeReturn = 1'b1;
      end
      default: begin
        strobes.takeMap = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/useq_addr_path.sv
module useq_addr_path
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int MAP_SHIFT  = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic [OPC_W-1:0]  opcodeBits,
  output logic [ADDR_W-1:0] ctlAddr,
  output logic [ADDR_W-1:0] retAddr
);

  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(RESET_ADDR);
  localparam logic [ADDR_W-1:0] ONE        = ADDR_W'(1);

  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] nextAddr;

  // Modulo increment: wraps from the top address to zero.
  assign seqAddr = ctlAddr + ONE;

  // Opcode lands at a routine boundary of 2**MAP_SHIFT words,
  // every other address bit cleared.
  always_comb begin
    mapAddr = '0;
    mapAddr[MAP_SHIFT +: OPC_W] = opcodeBits;
  end

  always_comb begin
    if (strobes.takeMap)         nextAddr = mapAddr;
    else if (strobes.takeReturn) nextAddr = retAddr;
    else if (strobes.takeTarget) nextAddr = branchTarget;
    else                         nextAddr = seqAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlAddr <= START_ADDR;
      retAddr <= '0;
    end else begin
      ctlAddr <= nextAddr;
      if (strobes.saveReturn) retAddr <= seqAddr;
    end
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int OPC_W      = 4,
  parameter int MAP_SHIFT  = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        condSel,
  input  logic [1:0]        branchKind,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic              indirectBit,
  input  logic [OPC_W-1:0]  opcodeBits,
  input  logic [DATA_W-1:0] acWord,
  output logic [ADDR_W-1:0] ctlAddr
);

  seqStrobes_t       strobes;
  logic [ADDR_W-1:0] retAddr;

  useq_branch_ctl #(
    .DATA_W(DATA_W)
  ) u_ctl (
    .condSel    (condSel),
    .branchKind (branchKind),
    .indirectBit(indirectBit),
    .acWord     (acWord),
    .strobes    (strobes)
  );

  useq_addr_path #(
    .ADDR_W    (ADDR_W),
    .OPC_W     (OPC_W),
    .MAP_SHIFT (MAP_SHIFT),
    .RESET_ADDR(RESET_ADDR)
  ) u_path (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .branchTarget(branchTarget),
    .opcodeBits  (opcodeBits),
    .ctlAddr     (ctlAddr),
    .retAddr     (retAddr)
  );

endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int OPC_W      = 4,
  parameter int MAP_SHIFT  = 2,
  parameter int RESET_ADDR = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        condSel,
  input logic [1:0]        branchKind,
  input logic [ADDR_W-1:0] branchTarget,
  input logic              indirectBit,
  input logic [OPC_W-1:0]  opcodeBits,
  input logic [DATA_W-1:0] acWord,
  input logic [ADDR_W-1:0] ctlAddr,
  input logic [ADDR_W-1:0] retAddr
);

  p_reset_start_r7: assert property (@(posedge clk)
    rst |=> (ctlAddr == ADDR_W'(RESET_ADDR)) && (retAddr == '0));

  p_uncond_jump_r2: assert property (@(posedge clk) disable iff (rst)
    (branchKind == 2'b00 && condSel == 2'b00) |=> ctlAddr == $past(branchTarget));

  p_indirect_jump_r1: assert property (@(posedge clk) disable iff (rst)
    (branchKind == 2'b00 && condSel == 2'b01 && indirectBit) |=> ctlAddr == $past(branchTarget));

  p_sign_fallthru_r3: assert property (@(posedge clk) disable iff (rst)
    (branchKind[1] == 1'b0 && condSel == 2'b10 && !acWord[DATA_W-1])
      |=> ctlAddr == ADDR_W'($past(ctlAddr) + 1'b1));

  p_call_link_r4: assert property (@(posedge clk) disable iff (rst)
    (branchKind == 2'b01 && condSel == 2'b00)
      |=> (retAddr == ADDR_W'($past(ctlAddr) + 1'b1)) && (ctlAddr == $past(branchTarget)));

  p_link_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (branchKind != 2'b01) |=> $stable(retAddr));

  p_return_r5: assert property (@(posedge clk) disable iff (rst)
    (branchKind == 2'b10) |=> ctlAddr == $past(retAddr));

  p_map_r6: assert property (@(posedge clk) disable iff (rst)
    (branchKind == 2'b11) |=> ctlAddr == ADDR_W'({$past(opcodeBits), MAP_SHIFT'(0)}));

endmodule

bind useq_next_addr useq_next_addr_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .OPC_W     (OPC_W),
  .MAP_SHIFT (MAP_SHIFT),
  .RESET_ADDR(RESET_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .condSel     (condSel),
  .branchKind  (branchKind),
  .branchTarget(branchTarget),
  .indirectBit (indirectBit),
  .opcodeBits  (opcodeBits),
  .acWord      (acWord),
  .ctlAddr     (ctlAddr),
  .retAddr     (retAddr)
);

// File: tb/useq_next_addr_bench.sv
`timescale 1ns/1ps
module useq_next_addr_bench;

  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  condSel = '0;
  logic [1:0]  branchKind = '0;
  logic [6:0]  branchTarget = '0;
  logic        indirectBit = 1'b0;
  logic [3:0]  opcodeBits = '0;
  logic [15:0] acWord = '0;
  logic [6:0]  ctlAddr;

  int checkCount = 0;
  int failCount  = 0;

  logic [6:0] addrModel = 7'd64;
  logic [6:0] linkModel = 7'd0;

  always #(PERIOD/2) clk = ~clk;

  useq_next_addr u_useq_next_addr (
    .clk         (clk),
    .rst         (rst),
    .condSel     (condSel),
    .branchKind  (branchKind),
    .branchTarget(branchTarget),
    .indirectBit (indirectBit),
    .opcodeBits  (opcodeBits),
    .acWord      (acWord),
    .ctlAddr     (ctlAddr)
  );

  task automatic check(input logic [6:0] got, input logic [6:0] want, input string tag);
    checkCount++;
    if (got !== want) begin
      failCount++;
      $display("FAIL %s: ctlAddr=%0d expected %0d", tag, got, want);
    end
  endtask

  function automatic logic condOf(input logic [1:0] cs, input logic ind, input logic [15:0] ac);
    case (cs)
      2'd0: return 1'b1;
      2'd1: return ind;
      2'd2: return ac[15];
      default: return (ac == 16'h0000);
    endcase
  endfunction

  // Applies one microinstruction, advances one clock, checks at the falling edge.
  task automatic step(input logic [1:0] cs, input logic [1:0] bk, input logic [6:0] tgt,
                      input logic ind, input logic [3:0] opc, input logic [15:0] ac);
    logic c;
    logic [6:0] want;
    string tag;
    condSel = cs; branchKind = bk; branchTarget = tgt;
    indirectBit = ind; opcodeBits = opc; acWord = ac;
    c = condOf(cs, ind, ac);
    case (bk)
      2'd0: begin want = c ? tgt : addrModel + 7'd1; tag = c ? "R2 R1 jump" : "R3 R1 jump step"; end
      2'd1: begin
        want = c ? tgt : addrModel + 7'd1;
        if (c) linkModel = addrModel + 7'd1;
        tag = c ? "R4 R1 call" : "R3 R1 call step";
      end
      2'd2: begin want = linkModel; tag = "R5 return"; end
      default: begin want = {1'b0, opc, 2'b00}; tag = "R6 map"; end
    endcase
    @(posedge clk);
    @(negedge clk);
    check(ctlAddr, want, tag);
    addrModel = want;
  endtask

  initial begin
    #(PERIOD * 150000);
    failCount++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    // R7: reset state
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(ctlAddr, 7'd64, "R7 reset start");
    rst = 1'b0;
    addrModel = 7'd64;
    linkModel = 7'd0;
    // R7: return register cleared, seen through a return
    step(2'd3, 2'd2, 7'd99, 1'b1, 4'd7, 16'h1234);

    // Sweep of selector x branch kind x status patterns (R1..R6)
    for (int cs = 0; cs < 4; cs++) begin
      for (int bk = 0; bk < 4; bk++) begin
        for (int t = 0; t < 8; t++) begin
          logic [15:0] ac;
          if (t[1])      ac = 16'h0000;
          else if (t[2]) ac = 16'h8000 | 16'(t * 16'h0131);
          else           ac = 16'h0123 + 16'(t);
          step(2'(cs), 2'(bk), 7'((cs * 37 + bk * 11 + t * 13) % 128),
               t[0], 4'((t * 3 + cs) % 16), ac);
        end
      end
    end

    // R4: link held across other kinds and an untaken call
    step(2'd0, 2'd1, 7'd20, 1'b0, 4'd0, 16'h0001);   // call taken from wherever
    step(2'd0, 2'd0, 7'd40, 1'b0, 4'd0, 16'h0001);   // jump
    step(2'd0, 2'd3, 7'd0,  1'b0, 4'd15, 16'h0001);  // map -> 60
    step(2'd2, 2'd1, 7'd5,  1'b0, 4'd0, 16'h0001);   // call not taken (sign clear)
    step(2'd1, 2'd1, 7'd6,  1'b0, 4'd0, 16'h0001);   // call not taken (indirect clear)
    step(2'd0, 2'd2, 7'd0,  1'b1, 4'd3, 16'h8000);   // return -> saved link

    // R3: wrap from 127 to 0
    step(2'd0, 2'd0, 7'd127, 1'b0, 4'd0, 16'h0000);
    step(2'd2, 2'd0, 7'd33,  1'b0, 4'd0, 16'h0001);
    // R4: call at 126 saves 127, call at 127 saves 0
    step(2'd0, 2'd0, 7'd126, 1'b0, 4'd0, 16'h0000);
    step(2'd3, 2'd1, 7'd10,  1'b0, 4'd0, 16'h0000);
    step(2'd0, 2'd2, 7'd0,   1'b0, 4'd0, 16'h0000);
    step(2'd0, 2'd1, 7'd11,  1'b0, 4'd0, 16'h0000);
    step(2'd0, 2'd2, 7'd0,   1'b0, 4'd0, 16'h0000);

    // R7: reset mid-run restores the start address and clears the link
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(ctlAddr, 7'd64, "R7 reset restart");
    rst = 1'b0;
    addrModel = 7'd64;
    linkModel = 7'd0;
    step(2'd0, 2'd2, 7'd50, 1'b0, 4'd0, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule